// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block watches every instruction fetch, store and load issued by a hart and decides whether any of four programmable debug triggers fires on it. Each trigger holds a control word and a compare value. The control word selects the operations and privilege levels the trigger watches, whether the address or the data is compared, one of six comparison modes, and whether the trigger is chained to the next one. The block produces a registered result: a valid flag and the index of the lowest-numbered trigger that fires.

Triggers are loaded through a simple write port. A one-bit selector picks the control word or the compare value, and an index picks the trigger. While the hart is halted in debug, nothing fires. A 32-bit-mode input narrows the compared value and the half-width used by the two masked modes.

Chaining joins neighbouring triggers into a group that fires only when every member matches. The index reported is that of the last member, the one whose chain bit is clear.

Top module: `trig_match_unit`

## Requirements
- R1: After active-low reset, `hitValid` is 0 and every control word is zero, so no access fires any trigger until a trigger is written.
- R2: `hitValid` and `hitIdx` are registered and describe the access presented in the preceding clock cycle. `hitIdx` is 0 whenever `hitValid` is 0.
- R3: A write with `wrSel`=0 loads `wrData[10:0]` into the control word of trigger `wrIdx`, and a write with `wrSel`=1 loads the full compare value. The control word fields are:
  - bit 0: execute enable
  - bit 1: store enable
  - bit 2: load enable
  - bit 3: U enable
  - bit 4: S enable
  - bit 5: M enable
  - bit 6: data select
  - bits 9:7: mode
  - bit 10: chain

  A write affects accesses from the following cycle on, not an access presented in the same cycle.
- R4: While `halted` is 1, no trigger fires.
- R5: `opKind` is coded 0 for execute, 1 for store, 2 for load and 3 for idle. A trigger is eligible only if its enable bit for the presented kind is set. Idle never fires.
- R6: `prvLevel` is coded 0 for U, 1 for S and 3 for M. A trigger is eligible only if its enable bit for that level is set. Code 2 never fires.
- R7: With data select set, `accData` is compared, otherwise `accAddr`. With `mode32` set, the chosen value is cleared above bit 31 before comparing, while the compare value is used as written.
- R8: Mode 0 fires when the value equals the compare value exactly.
- R9: Mode 1 counts the run of ones at the bottom of the compare value and ignores that many low bits. It fires when the remaining upper bits of the value and the compare value agree. An all-ones compare value matches everything.
- R10: Mode 2 fires when the value is greater than or equal to the compare value. Mode 3 fires when the value is strictly less than it. Both comparisons are unsigned.
- R11: Let h be 16 in 32-bit mode and 32 otherwise. Let mask be the compare value shifted right by h. Mode 4 fires when (value & mask) equals (compare & mask). Mode 5 fires when ((value >> h) & mask) equals (compare & mask). Modes 6 and 7 never fire.
- R12: When several unchained triggers fire, the lowest index is reported.
- R13: A trigger that matches with chain set reports nothing and lets the next trigger be considered. A trigger that fails (filter or compare) with chain set blocks every following trigger up to and including the next one whose chain bit is clear. Scanning resumes after that trigger. A chained trigger at the highest index never reports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control word, 1 selects the compare value |
| wrIdx | input | 2 | Trigger written |
| wrData | input | 64 | Write data |
| opKind | input | 2 | Access kind: 0 execute, 1 store, 2 load, 3 idle |
| accAddr | input | 64 | Access address |
| accData | input | 64 | Access data |
| prvLevel | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| mode32 | input | 1 | 32-bit mode |
| halted | input | 1 | Hart halted in debug |
| hitValid | output | 1 | A trigger fired on the previous cycle's access |
| hitIdx | output | 2 | Index of the reporting trigger |

## Verification
The assertions take for granted that `rstN` is held low for at least one edge before the first access. They also assume the write port and the access inputs change only between edges, so that a value captured by `$past` belongs to a single access. Under those assumptions the assertions check the following:
- a halted, idle or code-2 access yields no hit;
- a reported trigger had chain clear in the access cycle;
- a control write lands intact one edge later.

The stimulus drives every input on the falling edge and always applies reset first. It uses privilege code 2 and idle only in cases where it expects no hit, so the inputs stay inside these assumptions.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int TRIG_N = 4;
  localparam int XLEN   = 64;
  localparam int CTL_W  = 11;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_IDLE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    MODE_EQ    = 3'd0,
    MODE_NAPOT = 3'd1,
    MODE_GE    = 3'd2,
    MODE_LT    = 3'd3,
    MODE_MLO   = 3'd4,
    MODE_MHI   = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } mode_e;

  // Packed MSB first: chain is bit 10, exEn is bit 0.
  typedef struct packed {
    logic       chain;
    logic [2:0] mode;
    logic       selData;
    logic       mEn;
    logic       sEn;
    logic       uEn;
    logic       ldEn;
    logic       stEn;
    logic       exEn;
  } tctl_t;

  // Write strobes from control to datapath.
  typedef struct packed {
    logic [TRIG_N-1:0] ctlWr;
    logic [TRIG_N-1:0] cmpWr;
  } trig_strobe_t;

endpackage

// File: rtl/trig_dpath.sv
module trig_dpath
  import trig_pkg::*;
#(
  parameter int NUM = TRIG_N,
  parameter int XW  = XLEN
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trig_strobe_t         strobes,
  input  logic [XW-1:0]        wrData,
  input  logic [XW-1:0]        accAddr,
  input  logic [XW-1:0]        accData,
  input  logic                 mode32,
  output tctl_t [NUM-1:0]      ctlWords,
  output logic  [NUM-1:0]      cmpHit
);

  localparam int HALF = XW / 2;
  localparam logic [XW-1:0] LOW32 = {{(XW-32){1'b0}}, 32'hFFFF_FFFF};

  logic [XW-1:0] cmpVals [NUM];

  // Trigger registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlWords <= '0;
      for (int i = 0; i < NUM; i++) cmpVals[i] <= '0;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (strobes.ctlWr[i]) ctlWords[i] <= tctl_t'(wrData[CTL_W-1:0]);
        if (strobes.cmpWr[i]) cmpVals[i] <= wrData;
      end
    end
  end

  // One comparator set per trigger.
  for (genvar g = 0; g < NUM; g++) begin : gCmp
    logic [XW-1:0] selVal, cmpV, trailOnes, napotMask, halfMask, hiPart;

    always_comb begin
      cmpV      = cmpVals[g];
      selVal    = ctlWords[g].selData ? accData : accAddr;
      if (mode32) selVal = selVal & LOW32;
      trailOnes = cmpV & ~(cmpV + {{(XW-1){1'b0}}, 1'b1});
      napotMask = ~trailOnes;
      halfMask  = mode32 ? (cmpV >> 16) : (cmpV >> HALF);
      hiPart    = mode32 ? (selVal >> 16) : (selVal >> HALF);
      unique case (mode_e'(ctlWords[g].mode))
        MODE_EQ:    cmpHit[g] = (selVal == cmpV);
        MODE_NAPOT: cmpHit[g] = ((selVal & napotMask) == (cmpV & napotMask));
        MODE_GE:    cmpHit[g] = (selVal >= cmpV);
        MODE_LT:    cmpHit[g] = (selVal < cmpV);
        MODE_MLO:   cmpHit[g] = ((selVal & halfMask) == (cmpV & halfMask));
        MODE_MHI:   cmpHit[g] = ((hiPart & halfMask) == (cmpV & halfMask));
        default:    cmpHit[g] = 1'b0;
      endcase
    end

    // R3: a control strobe lands the written field image one edge later.
    assert_ctl_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobes.ctlWr[g] |=> (ctlWords[g] == $past(wrData[CTL_W-1:0])));
  end

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM   = TRIG_N,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [1:0]           opKind,
  input  logic [1:0]           prvLevel,
  input  logic                 halted,
  input  tctl_t [NUM-1:0]      ctlWords,
  input  logic  [NUM-1:0]      cmpHit,
  output trig_strobe_t         strobes,
  output logic                 hitValid,
  output logic [IDX_W-1:0]     hitIdx
);

  logic [NUM-1:0]   eligible;
  logic [NUM-1:0]   chainVec;
  logic             found;
  logic [IDX_W-1:0] foundIdx;

  // Write decode.
  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      strobes.ctlWr[i] = wrEn && !wrSel && (wrIdx == IDX_W'(i));
      strobes.cmpWr[i] = wrEn &&  wrSel && (wrIdx == IDX_W'(i));
    end
  end

  // Operation and privilege filters.
  for (genvar g = 0; g < NUM; g++) begin : gFilt
    logic opOk, prvOk;
    always_comb begin
      unique case (op_e'(opKind))
        OP_EXEC:  opOk = ctlWords[g].exEn;
        OP_STORE: opOk = ctlWords[g].stEn;
        OP_LOAD:  opOk = ctlWords[g].ldEn;
        default:  opOk = 1'b0;
      endcase
      unique case (prvLevel)
        2'd0:    prvOk = ctlWords[g].uEn;
        2'd1:    prvOk = ctlWords[g].sEn;
        2'd3:    prvOk = ctlWords[g].mEn;
        default: prvOk = 1'b0;
      endcase
    end
    assign eligible[g] = opOk && prvOk;
    assign chainVec[g] = ctlWords[g].chain;
  end

  // Priority scan with chaining.
  always_comb begin
    logic chainOk;
    chainOk  = 1'b1;
    found    = 1'b0;
    foundIdx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (!found) begin
        if (!chainOk) begin
          chainOk = !chainVec[i];
        end else if (eligible[i] && cmpHit[i]) begin
          if (!chainVec[i]) begin
            found    = 1'b1;
            foundIdx = IDX_W'(i);
          end
        end else if (chainVec[i]) begin
          chainOk = 1'b0;
        end
      end
    end
    if (halted) begin
      found    = 1'b0;
      foundIdx = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitIdx   <= '0;
    end else begin
      hitValid <= found;
      hitIdx   <= found ? foundIdx : '0;
    end
  end

  assert_halt_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> !hitValid);

  assert_idle_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 2'd3) |=> !hitValid);

  assert_priv_rsv_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (prvLevel == 2'd2) |=> !hitValid);

  assert_report_unchained_R13: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> ((($past(chainVec) >> hitIdx) & NUM'(1)) == '0));

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int NUM   = TRIG_N,
  parameter int XW    = XLEN,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [XW-1:0]    wrData,
  input  logic [1:0]       opKind,
  input  logic [XW-1:0]    accAddr,
  input  logic [XW-1:0]    accData,
  input  logic [1:0]       prvLevel,
  input  logic             mode32,
  input  logic             halted,
  output logic             hitValid,
  output logic [IDX_W-1:0] hitIdx
);

  trig_strobe_t       strobes;
  tctl_t [NUM-1:0]    ctlWords;
  logic  [NUM-1:0]    cmpHit;

  trig_ctrl #(.NUM(NUM), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .opKind(opKind), .prvLevel(prvLevel), .halted(halted),
    .ctlWords(ctlWords), .cmpHit(cmpHit),
    .strobes(strobes), .hitValid(hitValid), .hitIdx(hitIdx)
  );

  trig_dpath #(.NUM(NUM), .XW(XW)) uDpath (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .wrData(wrData),
    .accAddr(accAddr), .accData(accData), .mode32(mode32),
    .ctlWords(ctlWords), .cmpHit(cmpHit)
  );

endmodule

// File: tb/sim_trig_match_unit.sv
`timescale 1ns/1ps
module sim_trig_match_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [1:0]  opKind = 2'd3;
  logic [63:0] accAddr = '0, accData = '0;
  logic [1:0]  prvLevel = 2'd3;
  logic        mode32 = 1'b0, halted = 1'b0;
  logic        hitValid;
  logic [1:0]  hitIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [10:0] shCtl [4];
  logic [63:0] shCmp [4];

  always #5 clk = ~clk;

  trig_match_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .opKind(opKind), .accAddr(accAddr), .accData(accData),
    .prvLevel(prvLevel), .mode32(mode32), .halted(halted),
    .hitValid(hitValid), .hitIdx(hitIdx)
  );

  // Reference: does one trigger pass filters and compare (R5..R11).
  function automatic bit refOne(logic [10:0] c, logic [63:0] cv, int op,
                                logic [63:0] a, logic [63:0] d, int prv, bit m32);
    bit ok;
    logic [63:0] v, m;
    int t, h;
    case (op)
      0: ok = c[0];
      1: ok = c[1];
      2: ok = c[2];
      default: ok = 0;
    endcase
    case (prv)
      0: ok = ok & c[3];
      1: ok = ok & c[4];
      3: ok = ok & c[5];
      default: ok = 0;
    endcase
    if (!ok) return 0;
    v = c[6] ? d : a;
    if (m32) v = v & 64'hFFFF_FFFF;
    h = m32 ? 16 : 32;
    case (c[9:7])
      3'd0: return v == cv;
      3'd1: begin
        t = 0;
        while (t < 64 && cv[t]) t++;
        m = (t == 64) ? 64'd0 : ~((64'd1 << t) - 64'd1);
        return (v & m) == (cv & m);
      end
      3'd2: return v >= cv;
      3'd3: return v < cv;
      3'd4: begin m = cv >> h; return (v & m) == (cv & m); end
      3'd5: begin m = cv >> h; return ((v >> h) & m) == (cv & m); end
      default: return 0;
    endcase
  endfunction

  // Reference scan (R4, R12, R13). Returns {valid, idx}.
  function automatic logic [2:0] refScan(int op, logic [63:0] a, logic [63:0] d,
                                         int prv, bit m32, bit hl);
    bit chainOk = 1;
    if (hl) return 3'b000;
    for (int i = 0; i < 4; i++) begin
      if (!chainOk) begin
        chainOk = !shCtl[i][10];
      end else if (refOne(shCtl[i], shCmp[i], op, a, d, prv, m32)) begin
        if (!shCtl[i][10]) return {1'b1, 2'(i)};
      end else if (shCtl[i][10]) begin
        chainOk = 0;
      end
    end
    return 3'b000;
  endfunction

  task automatic check(string tag, logic gv, logic [1:0] gi, logic ev, logic [1:0] ei);
    checks++;
    if (gv !== ev || gi !== ei) begin
      errors++;
      $display("FAIL %s: got valid=%0d idx=%0d expected valid=%0d idx=%0d",
               tag, gv, gi, ev, ei);
    end
  endtask

  task automatic wr(bit sel, int idx, logic [63:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrIdx = 2'(idx); wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
    if (sel) shCmp[idx] = d; else shCtl[idx] = d[10:0];
  endtask

  task automatic acc(int op, logic [63:0] a, logic [63:0] d, int prv, bit m32,
                     bit hl, string tag);
    logic [2:0] e;
    @(negedge clk);
    opKind = 2'(op); accAddr = a; accData = d; prvLevel = 2'(prv);
    mode32 = m32; halted = hl;
    e = refScan(op, a, d, prv, m32, hl);
    @(posedge clk); #1;
    check(tag, hitValid, hitIdx, e[2], e[1:0]);
  endtask

  function automatic string modeTag(int md);
    case (md)
      0: return "R8";
      1: return "R9";
      2, 3: return "R10";
      default: return "R11";
    endcase
  endfunction

  logic [63:0] cmpSet [6];
  logic [63:0] valSet [8];

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin shCtl[i] = '0; shCmp[i] = '0; end
    cmpSet = '{64'h1000, 64'h100F, 64'hFFFF_FFFF_FFFF_FFFF,
               64'h0000_FFFF_0000_1234, 64'h8000_0000_0000_0000, 64'h0000_0000_FF00_0012};
    valSet = '{64'h1000, 64'h1007, 64'h100F, 64'h1010, 64'h0FFF,
               64'h1234_5678_0000_1234, 64'hFFFF_FFFF_0000_1000, 64'h0000_1234_0000_0000};

    repeat (3) @(posedge clk);
    #1 check("R1 reset", hitValid, hitIdx, 1'b0, 2'd0);
    @(negedge clk) rstN = 1;
    // R1: all triggers disabled after reset
    for (int op = 0; op < 3; op++)
      for (int p = 0; p < 4; p++)
        acc(op, 64'h0, 64'h0, p, 0, 0, "R1 disabled");

    // Mode sweep on trigger 0 (R7..R11)
    for (int md = 0; md < 8; md++)
      for (int sel = 0; sel < 2; sel++) begin
        wr(0, 0, 64'(11'h03F | (sel << 6) | (md << 7)));
        for (int ci = 0; ci < 6; ci++) begin
          wr(1, 0, cmpSet[ci]);
          for (int m = 0; m < 2; m++)
            for (int vi = 0; vi < 8; vi++)
              acc(0, sel ? ~valSet[vi] : valSet[vi], sel ? valSet[vi] : ~valSet[vi],
                  3, m[0], 0, modeTag(md));
        end
      end

    // R7: select and truncation directly
    wr(0, 0, 64'h03F);
    wr(1, 0, 64'h0000_0000_0000_4000);
    acc(0, 64'h0000_0001_0000_4000, 64'h0, 3, 1, 0, "R7 trunc32");
    acc(0, 64'h0000_0001_0000_4000, 64'h0, 3, 0, 0, "R7 full64");
    wr(0, 0, 64'h07F);
    acc(0, 64'h4000, 64'h5000, 3, 0, 0, "R7 data-select");
    acc(0, 64'h5000, 64'h4000, 3, 0, 0, "R7 data-select");

    // R5: operation filter
    for (int en = 0; en < 8; en++) begin
      wr(0, 0, 64'(11'h038 | en));
      for (int op = 0; op < 4; op++)
        acc(op, 64'h4000, 64'h0, 3, 0, 0, "R5 opfilter");
    end

    // R6: privilege filter
    for (int pe = 0; pe < 8; pe++) begin
      wr(0, 0, 64'(11'h007 | (pe << 3)));
      for (int p = 0; p < 4; p++)
        acc(0, 64'h4000, 64'h0, p, 0, 0, "R6 privfilter");
    end

    // R4: halted
    wr(0, 0, 64'h03F);
    acc(0, 64'h4000, 64'h0, 3, 0, 1, "R4 halted");
    acc(2, 64'h4000, 64'h0, 3, 0, 0, "R4 released");
    acc(0, 64'h4000, 64'h0, 3, 0, 0, "R4 released");

    // R2: output holds for one cycle after the access, then clears
    @(negedge clk);
    opKind = 2'd3;
    #3 check("R2 hold", hitValid, hitIdx, 1'b1, 2'd0);
    @(posedge clk); #1 check("R2 clear", hitValid, hitIdx, 1'b0, 2'd0);

    // R3: same-cycle write not visible, next cycle visible
    wr(0, 1, 64'h0);
    wr(0, 0, 64'h0);
    wr(1, 1, 64'h7000);
    @(negedge clk);
    wrEn = 1; wrSel = 0; wrIdx = 2'd1; wrData = 64'h03F;
    opKind = 2'd0; accAddr = 64'h7000; prvLevel = 2'd3; mode32 = 0; halted = 0;
    @(posedge clk); #1 check("R3 same-cycle", hitValid, hitIdx, 1'b0, 2'd0);
    wrEn = 0; shCtl[1] = 11'h03F;
    @(posedge clk); #1 check("R3 next-cycle", hitValid, hitIdx, 1'b1, 2'd1);

    // R12 / R13: chain and priority sweep, all triggers equality on address
    for (int cm = 0; cm < 16; cm++)
      for (int hm = 0; hm < 16; hm++) begin
        for (int i = 0; i < 4; i++) begin
          wr(0, i, 64'(11'h03F | (((cm >> i) & 1) << 10)));
          wr(1, i, ((hm >> i) & 1) ? 64'h9000 : 64'h9001);
        end
        acc(1, 64'h9000, 64'h0, 1, 0, 0, (cm == 0) ? "R12 priority" : "R13 chain");
      end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule